// File: doc/BRIEF.md
# Dual-Channel DAC Command Sequencer

This block sits on the controller side of a serial link to a dual-channel voltage DAC. Firmware or a neighbouring block hands it one high-level request at a time over a valid/ready handshake. A request can set the reference, write channel A, write channel B, load both channels so that they change together, or power the converter down. The sequencer turns each request into one or two 16-bit command words. It shifts each word out MSB first on a three-wire port made of an active-low chip select, a serial clock and a data line.

The timing of the port is derived from the system clock. Minimum times in nanoseconds for chip-select lead, clock high, clock low, data setup, data hold and chip-select trail are parameters. Each is rounded up to whole system-clock cycles. The receiver samples data on each falling serial-clock edge, so data changes only at the start of a high phase. A request to load both channels is sent as a buffer load followed by a channel-A write that also moves the buffer into channel B. The port stays idle for at least one serial-clock period between words and after the last word, and only then is the next request accepted.

Top module: `dacq_host_seq`

## Requirements
- R1: Out of reset, req_ready is 1, spi_csn is 1, and spi_sclk and spi_sdo are 0.
- R2: Each chip-select low period carries exactly 16 falling serial-clock edges. The bit sampled at the k-th falling edge is bit 15-k+1 of the command word, so the MSB goes first.
- R3: The serial clock stays high for at least max(ceil(T_HIGH_NS/T), ceil(T_SETUP_NS/T)) cycles. Between bits it stays low for at least max(ceil(T_LOW_NS/T), ceil(T_HOLD_NS/T)) cycles, where T is CLK_PERIOD_NS.
- R4: spi_sdo holds its value through every high phase of the serial clock and through the first cycle after each falling edge.
- R5: spi_sclk is 0 whenever spi_csn is 1. spi_csn is low for at least ceil(T_CSS_NS/T) cycles before the first rising serial-clock edge of a word.
- R6: After the 16th falling edge, spi_csn stays low for at least max(low-phase cycles, ceil(T_CSH_NS/T)) cycles.
- R7: Word layout: bit 15 and bit 12 form the 2-bit select code, with bit 15 as the high bit. Bit 14 is req_fast, bit 13 is power-down, and bits 11..0 are the payload. Request kinds on req_kind are: 0 set reference, 1 write A, 2 write B, 3 write both, 4 power down.
- R8: Write A sends one word with select 10, the payload being req_code_a in bits 11..2 and 00 in bits 1..0. Write B sends one word with select 00 and req_code_b placed the same way. Bit 13 is 0 in both.
- R9: Write both sends two words in this order. The first has select 01 and carries req_code_b. The second has select 10 and carries req_code_a. Both have bit 13 at 0 and bits 1..0 at 00.
- R10: Set reference sends one word with select 11, bit 13 at 0, bits 11..2 at zero and req_ref in bits 1..0.
- R11: Power down sends one word with select 11, bit 13 at 1, bits 11..2 at zero and req_ref in bits 1..0.
- R12: req_ready falls in the cycle after a request is accepted. It stays low until spi_csn has been high for at least one serial-clock period (high plus low phase cycles) after the last word. Chip select is also high for at least that long between two words. Inputs presented while req_ready is low are ignored.
- R13: Kinds 5, 6 and 7 are accepted but send no word, and req_ready returns within two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_kind | input | 3 | Request kind (R7) |
| req_code_a | input | 10 | Channel A code |
| req_code_b | input | 10 | Channel B code |
| req_ref | input | 2 | Reference code for control words |
| req_fast | input | 1 | Speed-mode bit put in every word |
| spi_csn | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_sdo | output | 1 | Serial data to the converter |

## Verification
The bench builds the block with a 10 ns clock and a 35 ns low time against a 25 ns high time. This gives 3 high cycles, 4 low cycles, 4 trailing cycles and a 7-cycle gap, so a swap of the high and low rules or a lost rounding step shows up as a length error. Each request runs about 130 cycles, which allows a near-exhaustive sweep over all eight kinds, both speed settings, all four reference codes and four code patterns. Every frame is decoded from the pins and compared bit for bit.

// File: rtl/dacq_pkg.sv
package dacq_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned CODE_W = 10;
  localparam int unsigned PAY_W  = 12;

  typedef enum logic [2:0] {
    REQ_SET_REF    = 3'd0,
    REQ_WR_A       = 3'd1,
    REQ_WR_B       = 3'd2,
    REQ_WR_BOTH    = 3'd3,
    REQ_POWER_DOWN = 3'd4
  } req_kind_e;

  localparam logic [1:0] SEL_B_AND_BUF = 2'b00;
  localparam logic [1:0] SEL_BUF_ONLY  = 2'b01;
  localparam logic [1:0] SEL_A_UPDATE  = 2'b10;
  localparam logic [1:0] SEL_CONTROL   = 2'b11;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Select high bit at 15, select low bit at 12.
  function automatic logic [WORD_W-1:0] pack_word(input logic [1:0] sel, input logic fast,
                                                  input logic pd, input logic [PAY_W-1:0] pay);
    return {sel[1], fast, pd, sel[0], pay};
  endfunction

  function automatic logic [PAY_W-1:0] code_payload(input logic [CODE_W-1:0] code);
    return {code, {(PAY_W-CODE_W){1'b0}}};
  endfunction

  function automatic logic [PAY_W-1:0] ref_payload(input logic [1:0] rsel);
    return {{(PAY_W-2){1'b0}}, rsel};
  endfunction

endpackage

// File: rtl/dacq_cmd_expand.sv
module dacq_cmd_expand
  import dacq_pkg::*;
(
  input  logic [2:0]        kind_i,
  input  logic [CODE_W-1:0] code_a_i,
  input  logic [CODE_W-1:0] code_b_i,
  input  logic [1:0]        ref_i,
  input  logic              fast_i,
  output logic [WORD_W-1:0] word0_o,
  output logic [WORD_W-1:0] word1_o,
  output logic [1:0]        nwords_o
);

  always_comb begin
    word0_o  = '0;
    word1_o  = '0;
    nwords_o = 2'd0;
    case (kind_i)
      REQ_SET_REF: begin
        word0_o  = pack_word(SEL_CONTROL, fast_i, 1'b0, ref_payload(ref_i));
        nwords_o = 2'd1;
      end
      REQ_WR_A: begin
        word0_o  = pack_word(SEL_A_UPDATE, fast_i, 1'b0, code_payload(code_a_i));
        nwords_o = 2'd1;
      end
      REQ_WR_B: begin
        word0_o  = pack_word(SEL_B_AND_BUF, fast_i, 1'b0, code_payload(code_b_i));
        nwords_o = 2'd1;
      end
      REQ_WR_BOTH: begin
        // buffer first, then channel A with the simultaneous update
        word0_o  = pack_word(SEL_BUF_ONLY, fast_i, 1'b0, code_payload(code_b_i));
        word1_o  = pack_word(SEL_A_UPDATE, fast_i, 1'b0, code_payload(code_a_i));
        nwords_o = 2'd2;
      end
      REQ_POWER_DOWN: begin
        word0_o  = pack_word(SEL_CONTROL, fast_i, 1'b1, ref_payload(ref_i));
        nwords_o = 2'd1;
      end
      default: nwords_o = 2'd0;
    endcase
  end

endmodule

// File: rtl/dacq_frame_shifter.sv
module dacq_frame_shifter
  import dacq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_CSS_NS      = 10,
  parameter int unsigned T_HIGH_NS     = 25,
  parameter int unsigned T_LOW_NS      = 25,
  parameter int unsigned T_SETUP_NS    = 10,
  parameter int unsigned T_HOLD_NS     = 5,
  parameter int unsigned T_CSH_NS      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              busy_o,
  output logic              csn_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              fall_o
);

  localparam int unsigned CSS_CYC = ns_to_cyc(T_CSS_NS, CLK_PERIOD_NS);
  localparam int unsigned HI_CYC  = ns_to_cyc(T_HIGH_NS, CLK_PERIOD_NS);
  localparam int unsigned LO_CYC  = ns_to_cyc(T_LOW_NS, CLK_PERIOD_NS);
  localparam int unsigned SU_CYC  = ns_to_cyc(T_SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned HD_CYC  = ns_to_cyc(T_HOLD_NS, CLK_PERIOD_NS);
  localparam int unsigned CSH_CYC = ns_to_cyc(T_CSH_NS, CLK_PERIOD_NS);
  localparam int unsigned HI_PH   = max2(HI_CYC, SU_CYC);
  localparam int unsigned LO_PH   = max2(LO_CYC, HD_CYC);
  localparam int unsigned TAIL_PH = max2(LO_PH, CSH_CYC);
  localparam int unsigned GAP_PH  = HI_PH + LO_PH;
  localparam int unsigned TOP_PH  = max2(max2(GAP_PH, TAIL_PH), CSS_CYC);
  localparam int unsigned CW      = $clog2(TOP_PH + 1);
  localparam int unsigned BW      = $clog2(WORD_W);
  localparam logic [BW:0] FALLS_PER_WORD = (BW+1)'(WORD_W);

  typedef enum logic [2:0] {SH_IDLE, SH_LEAD, SH_HIGH, SH_LOW, SH_TAIL, SH_GAP} sh_state_e;

  sh_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic [BW-1:0]     bidx_q;
  logic              cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      bidx_q  <= '0;
    end else begin
      case (state_q)
        SH_IDLE: if (start_i) begin
          state_q <= SH_LEAD;
          cnt_q   <= CW'(CSS_CYC - 1);
          sh_q    <= word_i;
          bidx_q  <= BW'(WORD_W - 1);
        end
        SH_LEAD: if (cnt_zero) begin
          state_q <= SH_HIGH;
          cnt_q   <= CW'(HI_PH - 1);
        end else cnt_q <= cnt_q - 1'b1;
        SH_HIGH: if (cnt_zero) begin
          if (bidx_q == '0) begin
            state_q <= SH_TAIL;
            cnt_q   <= CW'(TAIL_PH - 1);
          end else begin
            state_q <= SH_LOW;
            cnt_q   <= CW'(LO_PH - 1);
          end
        end else cnt_q <= cnt_q - 1'b1;
        SH_LOW: if (cnt_zero) begin
          state_q <= SH_HIGH;
          cnt_q   <= CW'(HI_PH - 1);
          sh_q    <= {sh_q[WORD_W-2:0], 1'b0};
          bidx_q  <= bidx_q - 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        SH_TAIL: if (cnt_zero) begin
          state_q <= SH_GAP;
          cnt_q   <= CW'(GAP_PH - 1);
        end else cnt_q <= cnt_q - 1'b1;
        SH_GAP: if (cnt_zero) state_q <= SH_IDLE;
                else cnt_q <= cnt_q - 1'b1;
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != SH_IDLE);
  assign csn_o  = !((state_q == SH_LEAD) || (state_q == SH_HIGH) ||
                    (state_q == SH_LOW)  || (state_q == SH_TAIL));
  assign sclk_o = (state_q == SH_HIGH);
  assign sdo_o  = csn_o ? 1'b0 : sh_q[WORD_W-1];
  assign fall_o = (state_q == SH_HIGH) && cnt_zero;

  // Pin-level observers feeding the assertions below.
  logic [CW-1:0] hi_run_q;
  logic [CW-1:0] since_fall_q;
  logic [BW:0]   falls_q;
  logic          sclk_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q     <= '0;
      since_fall_q <= '0;
      falls_q      <= '0;
      sclk_d_q     <= 1'b0;
    end else begin
      sclk_d_q <= sclk_o;
      hi_run_q <= sclk_o ? hi_run_q + 1'b1 : '0;
      if (sclk_d_q && !sclk_o)          since_fall_q <= CW'(1);
      else if (since_fall_q != '1)      since_fall_q <= since_fall_q + 1'b1;
      if (csn_o)                        falls_q <= '0;
      else if (sclk_d_q && !sclk_o)     falls_q <= falls_q + 1'b1;
    end
  end

  p_sclk_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    csn_o |-> !sclk_o);
  p_sdo_steady_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));
  p_sdo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> $stable(sdo_o));
  p_high_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> (hi_run_q >= CW'(HI_CYC)));
  p_tail_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csn_o) |-> (since_fall_q >= CW'(CSH_CYC)));
  p_sixteen_falls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csn_o) |-> ((falls_q + (sclk_d_q && !sclk_o)) == FALLS_PER_WORD));

endmodule

// File: rtl/dacq_host_seq.sv
module dacq_host_seq
  import dacq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_CSS_NS      = 10,
  parameter int unsigned T_HIGH_NS     = 25,
  parameter int unsigned T_LOW_NS      = 25,
  parameter int unsigned T_SETUP_NS    = 10,
  parameter int unsigned T_HOLD_NS     = 5,
  parameter int unsigned T_CSH_NS      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [CODE_W-1:0] req_code_a,
  input  logic [CODE_W-1:0] req_code_b,
  input  logic [1:0]        req_ref,
  input  logic              req_fast,
  output logic              spi_csn,
  output logic              spi_sclk,
  output logic              spi_sdo
);

  logic [WORD_W-1:0] exp_w0, exp_w1;
  logic [1:0]        exp_n;
  logic [WORD_W-1:0] words_q [2];
  logic [1:0]        left_q;
  logic              idx_q;
  logic              rdy_q;
  logic              start_q;
  logic [WORD_W-1:0] cur_word_q;
  logic              sh_busy;
  logic              sh_fall;
  logic              accept;

  dacq_cmd_expand u_expand (
    .kind_i   (req_kind),
    .code_a_i (req_code_a),
    .code_b_i (req_code_b),
    .ref_i    (req_ref),
    .fast_i   (req_fast),
    .word0_o  (exp_w0),
    .word1_o  (exp_w1),
    .nwords_o (exp_n)
  );

  assign accept = req_valid && rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q      <= 1'b1;
      words_q[0] <= '0;
      words_q[1] <= '0;
      left_q     <= '0;
      idx_q      <= 1'b0;
      start_q    <= 1'b0;
      cur_word_q <= '0;
    end else begin
      start_q <= 1'b0;
      if (accept) begin
        rdy_q      <= 1'b0;
        words_q[0] <= exp_w0;
        words_q[1] <= exp_w1;
        left_q     <= exp_n;
        idx_q      <= 1'b0;
      end else if (!rdy_q && !start_q && !sh_busy) begin
        if (left_q != '0) begin
          start_q    <= 1'b1;
          cur_word_q <= words_q[idx_q];
          idx_q      <= 1'b1;
          left_q     <= left_q - 1'b1;
        end else begin
          rdy_q <= 1'b1;
        end
      end
    end
  end

  assign req_ready = rdy_q;

  dacq_frame_shifter #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_CSS_NS      (T_CSS_NS),
    .T_HIGH_NS     (T_HIGH_NS),
    .T_LOW_NS      (T_LOW_NS),
    .T_SETUP_NS    (T_SETUP_NS),
    .T_HOLD_NS     (T_HOLD_NS),
    .T_CSH_NS      (T_CSH_NS)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_q),
    .word_i  (cur_word_q),
    .busy_o  (sh_busy),
    .csn_o   (spi_csn),
    .sclk_o  (spi_sclk),
    .sdo_o   (spi_sdo),
    .fall_o  (sh_fall)
  );

  p_accept_drops_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_ready_port_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (spi_csn && !spi_sclk && !sh_busy));
  p_unknown_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_kind > 3'd4)) |=> (spi_csn && !start_q));
  p_fall_only_low_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sh_fall |-> !spi_csn);

endmodule

// File: tb/dacq_host_seq_tb.sv
module dacq_host_seq_tb;

  localparam int unsigned CLKP = 10;
  localparam int unsigned TCSS = 10, THI = 25, TLO = 35, TSU = 10, THD = 5, TCSH = 10;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLKP - 1) / CLKP;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int HI_EXP   = (cyc(THI) > cyc(TSU)) ? cyc(THI) : cyc(TSU);
  localparam int LO_EXP   = (cyc(TLO) > cyc(THD)) ? cyc(TLO) : cyc(THD);
  localparam int TAIL_EXP = (LO_EXP > cyc(TCSH)) ? LO_EXP : cyc(TCSH);
  localparam int LEAD_EXP = cyc(TCSS);
  localparam int GAP_EXP  = HI_EXP + LO_EXP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_kind = '0;
  logic [9:0] req_code_a = '0, req_code_b = '0;
  logic [1:0] req_ref = '0;
  logic req_fast = 1'b0;
  logic spi_csn, spi_sclk, spi_sdo;

  always #5 clk = ~clk;

  dacq_host_seq #(
    .CLK_PERIOD_NS(CLKP), .T_CSS_NS(TCSS), .T_HIGH_NS(THI), .T_LOW_NS(TLO),
    .T_SETUP_NS(TSU), .T_HOLD_NS(THD), .T_CSH_NS(TCSH)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_code_a(req_code_a), .req_code_b(req_code_b),
    .req_ref(req_ref), .req_fast(req_fast),
    .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_sdo(spi_sdo)
  );

  int n_chk = 0, n_bad = 0;
  int m_chk = 0, m_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Pin monitor: decodes frames and measures phase lengths.
  logic [15:0] frames [8];
  int fr_total = 0;
  int nfall = 0, hi_run = 0, lo_run = 0, sf = 0, lead = 0, csh_run = 100;
  logic [15:0] sr = '0;
  logic prev_csn = 1'b1, prev_sclk = 1'b0, prev_sdo = 1'b0;
  bit seen_frame = 0;

  function automatic void mchk(input bit ok, input string tag, input int act, input int exp);
    m_chk++;
    if (!ok) begin
      m_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (!spi_csn) begin
        if (prev_csn) begin
          if (seen_frame) mchk(csh_run >= GAP_EXP, "R12 cs high gap between words", csh_run, GAP_EXP);
          nfall = 0; lead = 0; hi_run = 0; lo_run = 0; sf = 0;
        end
        if (spi_sclk && !prev_sclk) begin
          if (nfall == 0) mchk(lead >= LEAD_EXP, "R5 cs lead before first clock", lead, LEAD_EXP);
          else            mchk(lo_run >= LO_EXP, "R3 low phase", lo_run, LO_EXP);
          hi_run = 0;
        end
        if (spi_sclk) hi_run++;
        if (!spi_sclk && prev_sclk) begin
          mchk(hi_run >= HI_EXP, "R3 high phase", hi_run, HI_EXP);
          mchk(spi_sdo == prev_sdo, "R4 data steady across falling edge", spi_sdo, prev_sdo);
          sr = {sr[14:0], spi_sdo};
          nfall++; sf = 0; lo_run = 0;
        end
        if (!spi_sclk) begin
          lo_run++; sf++;
          if (nfall == 0) lead++;
        end
        if (spi_sclk && prev_sclk)
          mchk(spi_sdo == prev_sdo, "R4 data steady in high phase", spi_sdo, prev_sdo);
      end else begin
        if (!prev_csn) begin
          mchk(nfall == 16, "R2 falling edges per word", nfall, 16);
          mchk(sf >= TAIL_EXP, "R6 cs trail after last edge", sf, TAIL_EXP);
          frames[fr_total % 8] = sr;
          fr_total++;
          seen_frame = 1;
          csh_run = 0;
        end
        csh_run++;
        if (spi_sclk) mchk(1'b0, "R5 clock while deselected", 1, 0);
      end
      prev_csn = spi_csn; prev_sclk = spi_sclk; prev_sdo = spi_sdo;
    end
  end

  function automatic logic [15:0] want_word(input int k, input int pos, input logic [9:0] a,
                                            input logic [9:0] b, input logic [1:0] r, input logic f);
    logic [15:0] w;
    w = 16'h0;
    w[14] = f;
    case (k)
      0: begin w[15] = 1'b1; w[12] = 1'b1; w[1:0] = r; end
      1: begin w[15] = 1'b1; w[11:2] = a; end
      2: w[11:2] = b;
      3: if (pos == 0) begin w[12] = 1'b1; w[11:2] = b; end
         else begin w[15] = 1'b1; w[11:2] = a; end
      4: begin w[15] = 1'b1; w[13] = 1'b1; w[12] = 1'b1; w[1:0] = r; end
      default: w = 16'h0;
    endcase
    return w;
  endfunction

  function automatic string kind_tag(input int k);
    case (k)
      0: return "R10 set reference word";
      1: return "R8 write A word";
      2: return "R8 write B word";
      3: return "R9 write both word";
      4: return "R11 power down word";
      default: return "R13 unknown kind";
    endcase
  endfunction

  task automatic send(input int k, input logic [9:0] a, input logic [9:0] b,
                      input logic [1:0] r, input logic f);
    int start_fr, wait_c, nexp;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    start_fr = fr_total;
    req_kind = 3'(k); req_code_a = a; req_code_b = b; req_ref = r; req_fast = f;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(req_ready == 1'b0, "R12 ready drops after accept", req_ready, 0);
    nexp = (k == 3) ? 2 : ((k <= 4) ? 1 : 0);
    if (nexp > 0) begin
      // R12: inputs while busy must be ignored
      req_kind = 3'd0; req_code_a = ~a; req_code_b = ~b; req_ref = ~r; req_fast = ~f;
      req_valid = 1'b1;
      repeat (4) @(negedge clk);
      req_valid = 1'b0;
    end
    wait_c = 1;
    while (!req_ready && wait_c < 2000) begin
      @(negedge clk);
      wait_c++;
    end
    #1;
    if (nexp == 0) begin
      chk(wait_c <= 2, "R13 ready returns quickly", wait_c, 2);
      chk(fr_total == start_fr, "R13 no word for unknown kind", fr_total - start_fr, 0);
    end else begin
      chk(csh_run >= GAP_EXP, "R12 idle gap before ready", csh_run, GAP_EXP);
      chk(fr_total - start_fr == nexp, "R9 R12 word count", fr_total - start_fr, nexp);
      for (int i = 0; i < nexp; i++)
        chk(frames[(start_fr + i) % 8] == want_word(k, i, a, b, r, f), kind_tag(k),
            frames[(start_fr + i) % 8], want_word(k, i, a, b, r, f));
    end
  endtask

  function automatic logic [9:0] pat(input int i);
    case (i)
      0: return 10'h000;
      1: return 10'h3FF;
      2: return 10'h155;
      default: return 10'h2B6;
    endcase
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + m_chk + 1, n_bad + m_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(spi_csn == 1'b1, "R1 reset csn", spi_csn, 1);
    chk(spi_sclk == 1'b0, "R1 reset sclk", spi_sclk, 0);
    chk(spi_sdo == 1'b0, "R1 reset sdo", spi_sdo, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(req_ready == 1'b1 && spi_csn == 1'b1, "R1 idle after release", {req_ready, spi_csn}, 3);
    for (int k = 0; k < 8; k++)
      for (int f = 0; f < 2; f++)
        for (int r = 0; r < 4; r++)
          for (int p = 0; p < 4; p++)
            send(k, pat(p), ~pat((p + r) % 4), 2'(r), 1'(f));
    // R7 R9: back-to-back simultaneous updates with distinct codes
    send(3, 10'h001, 10'h200, 2'd1, 1'b1);
    send(3, 10'h200, 10'h001, 2'd2, 1'b0);
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + m_chk, n_bad + m_bad);
    $finish;
  end

endmodule